// File: doc/BRIEF.md
# Real-Time Clock Snapshot and Update Controller

This block is the timekeeping core of a real-time clock together with the control logic around the registers that software sees. Seven running counters hold seconds, minutes, hours, day of week, date, month and year in packed BCD. They advance once for every strobe on a 1 Hz tick input. Software does not read these counters directly. It sees a separate bank of seven user time registers, and a control register moves data between the two. A rising edge of the capture bit copies the whole running time into the bank in one clock edge. Setting the freeze bit stops counting. Clearing the freeze bit again loads the bank into the counters, and counting restarts.

The control register also holds a calibration-mode enable and a century flag. The century flag is set when the year wraps from 99 to 00, and it clears when software reads the control register. A calibration register holds a sign bit and a 5-bit magnitude, and both go straight out to the calibration logic outside the block. A mux output carries the external calibration clock while calibration mode is on. Otherwise it carries the power-fail comparator input.

The register port is a request/response pair with a valid strobe on each side. The port has no back-pressure and no ready signal. Every request is taken in the cycle in which it is presented. A read answers exactly one cycle later, with `rsp_valid_o` high for one cycle. Requests may arrive back to back in consecutive cycles.

Top module: `rtc_snap_ctrl`

## Requirements
- R1: Address map: 0 is control, 1 is calibration, and 2 to 8 are the user time registers (seconds, minutes, hours, day, date, month, year). A read request gives `rsp_valid_o` and the data on the next cycle. Other addresses read as 0x00 and ignore writes.
- R2: On an accepted tick, seconds and minutes wrap from 0x59 to 0x00 and carry; hours wrap from 0x23 to 0x00; the day of week counts 0x01 to 0x07 and then wraps to 0x01.
- R3: The date wraps to 0x01 after the last day of the month (30 for months 04, 06, 09 and 11; 31 for the other months; for 02 it is 29 when the year is a multiple of 4, 00 included, and 28 otherwise). The month wraps from 0x12 to 0x01 and carries into the year, which wraps from 0x99 to 0x00.
- R4: A write to control that takes bit 0 from 0 to 1 copies all seven counters into the user bank at that clock edge, as one image.
- R5: A control write with bit 0 = 1 while bit 0 is already 1 leaves the user bank unchanged.
- R6: While bit 1 of control is 1, ticks are discarded. The user time registers then read back the last value written or captured.
- R7: A control write that takes bit 1 from 1 to 0 loads the user bank into the counters, and counting resumes from those values. A tick in that same cycle is discarded.
- R8: Bit 6 of control is set when the year wraps from 99 to 00, and software cannot write it. A read of control returns the value it had before the read, then clears it. A wrap in the same cycle as such a read leaves the bit set.
- R9: Control bit 2 is the calibration-mode enable. Bits 7 and 5 to 3 read as 0 whatever was written.
- R10: Calibration register bit 5 is the sign and bits 4 to 0 are the magnitude. Bits 7 and 6 read as 0. Both fields drive `cal_sign_o` and `cal_mag_o`.
- R11: `cal_pfo_o` follows `cal_clk_i` while control bit 2 is 1, and follows `pfail_i` while it is 0. `cal_mode_o` equals control bit 2.
- R12: After reset, the control and calibration registers are 0x00, and the counters and the user bank hold 00:00:00, day 01, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe, once per second |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid (one cycle after the read request) |
| rsp_rdata_o | output | 8 | Read data |
| cal_clk_i | input | 1 | Calibration signal from the external pulse shaper |
| pfail_i | input | 1 | Power-fail comparator input |
| cal_pfo_o | output | 1 | Shared calibration / power-fail output |
| cal_mode_o | output | 1 | Calibration mode active |
| cal_sign_o | output | 1 | Calibration sign |
| cal_mag_o | output | 5 | Calibration magnitude |

## Verification
A year wrap and a read of the control register can fall in the same cycle. The bench provokes this by loading 23:59:59 on 31 December of year 99 and then driving the tick and the control read in one clock cycle. The response must show the flag as clear, and the next read must show it set, which confirms that the set wins over the clear. Sweeps over month ends, leap and non-leap Februaries and a long run of ticks are compared against an arithmetic model of the calendar.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  parameter int DATA_W   = 8;
  parameter int ADDR_W   = 4;
  parameter int NUM_TIME = 7;
  parameter int CAL_W    = 5;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam int ADDR_CTL   = 0;
  localparam int ADDR_CAL   = 1;
  localparam int ADDR_TIME0 = 2;

  localparam int CTL_RD_BIT  = 0;
  localparam int CTL_WR_BIT  = 1;
  localparam int CTL_CAL_BIT = 2;
  localparam int CTL_CF_BIT  = 6;
  localparam int CAL_SIGN_BIT = CAL_W;

  typedef logic [NUM_TIME-1:0][DATA_W-1:0] time_bank_t;

  localparam time_bank_t FIELD_RST = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam time_bank_t FIELD_LO  = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam time_bank_t FIELD_HI  = {8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59};

  function automatic logic [DATA_W-1:0] bcd_next(input logic [DATA_W-1:0] v,
                                                  input logic [DATA_W-1:0] lo,
                                                  input logic [DATA_W-1:0] hi);
    if (v == hi)            return lo;
    else if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'd0};
    else                     return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [DATA_W-1:0] month_last(input logic [DATA_W-1:0] mon,
                                                    input logic [DATA_W-1:0] yr);
    logic [4:0] md4;
    md4 = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    case (mon)
      8'h02:                      return (md4[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_snap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       freeze_i,
  input  logic       load_i,
  input  time_bank_t load_val_i,
  output time_bank_t cnt_o,
  output logic       century_o
);
  time_bank_t cnt_q;
  time_bank_t hi;
  logic [NUM_TIME-1:0] en;

  always_comb begin
    hi          = FIELD_HI;
    hi[F_DATE]  = month_last(cnt_q[F_MON], cnt_q[F_YEAR]);
    en[F_SEC]   = tick_i && !freeze_i && !load_i;
    en[F_MIN]   = en[F_SEC]  && (cnt_q[F_SEC]  == hi[F_SEC]);
    en[F_HOUR]  = en[F_MIN]  && (cnt_q[F_MIN]  == hi[F_MIN]);
    en[F_DAY]   = en[F_HOUR] && (cnt_q[F_HOUR] == hi[F_HOUR]);
    en[F_DATE]  = en[F_DAY];
    en[F_MON]   = en[F_DATE] && (cnt_q[F_DATE] == hi[F_DATE]);
    en[F_YEAR]  = en[F_MON]  && (cnt_q[F_MON]  == hi[F_MON]);
    century_o   = en[F_YEAR] && (cnt_q[F_YEAR] == hi[F_YEAR]);
  end

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[i] <= FIELD_RST[i];
      else if (load_i) cnt_q[i] <= load_val_i[i];
      else if (en[i])  cnt_q[i] <= bcd_next(cnt_q[i], FIELD_LO[i], hi[i]);
    end
  end

  assign cnt_o = cnt_q;

  assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !load_i) |=> $stable(cnt_q));
  assert_load_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_i && !load_i && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00));
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  time_bank_t        cnt_i,
  input  logic              century_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              freeze_o,
  output logic              load_o,
  output time_bank_t        bank_o,
  output logic              cal_en_o,
  output logic              cal_sign_o,
  output logic [CAL_W-1:0]  cal_mag_o
);
  logic wr, rd, wr_ctl, rd_ctl, cap;
  logic rd_q, wr_q, cal_q, cf_q, sign_q;
  logic [CAL_W-1:0] mag_q;
  time_bank_t bank_q;
  logic [DATA_W-1:0] rdata_d;

  assign wr     = req_valid_i && req_write_i;
  assign rd     = req_valid_i && !req_write_i;
  assign wr_ctl = wr && (req_addr_i == ADDR_W'(ADDR_CTL));
  assign rd_ctl = rd && (req_addr_i == ADDR_W'(ADDR_CTL));
  assign cap    = wr_ctl && req_wdata_i[CTL_RD_BIT] && !rd_q;
  assign load_o = wr_ctl && wr_q && !req_wdata_i[CTL_WR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0; wr_q <= 1'b0; cal_q <= 1'b0;
    end else if (wr_ctl) begin
      rd_q  <= req_wdata_i[CTL_RD_BIT];
      wr_q  <= req_wdata_i[CTL_WR_BIT];
      cal_q <= req_wdata_i[CTL_CAL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cf_q <= 1'b0;
    else if (century_i) cf_q <= 1'b1;
    else if (rd_ctl)    cf_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0; mag_q <= '0;
    end else if (wr && req_addr_i == ADDR_W'(ADDR_CAL)) begin
      sign_q <= req_wdata_i[CAL_SIGN_BIT];
      mag_q  <= req_wdata_i[CAL_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          bank_q[i] <= FIELD_RST[i];
      else if (wr && req_addr_i == ADDR_W'(ADDR_TIME0 + i)) bank_q[i] <= req_wdata_i;
      else if (cap)                                         bank_q[i] <= cnt_i[i];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (req_addr_i == ADDR_W'(ADDR_CTL)) begin
      rdata_d[CTL_RD_BIT]  = rd_q;
      rdata_d[CTL_WR_BIT]  = wr_q;
      rdata_d[CTL_CAL_BIT] = cal_q;
      rdata_d[CTL_CF_BIT]  = cf_q;
    end else if (req_addr_i == ADDR_W'(ADDR_CAL)) begin
      rdata_d[CAL_SIGN_BIT] = sign_q;
      rdata_d[CAL_W-1:0]    = mag_q;
    end
    for (int i = 0; i < NUM_TIME; i++)
      if (req_addr_i == ADDR_W'(ADDR_TIME0 + i)) rdata_d = bank_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0; rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rdata_d;
    end
  end

  assign freeze_o   = wr_q;
  assign bank_o     = bank_q;
  assign cal_en_o   = cal_q;
  assign cal_sign_o = sign_q;
  assign cal_mag_o  = mag_q;

  assert_cf_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    century_i |=> cf_q);
  assert_cf_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && !century_i) |=> !cf_q);
  assert_held_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && rd_q && req_wdata_i[CTL_RD_BIT]) |=> $stable(bank_q));
  assert_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid_o);
endmodule

// File: rtl/rtc_snap_ctrl.sv
module rtc_snap_ctrl
  import rtc_snap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              cal_clk_i,
  input  logic              pfail_i,
  output logic              cal_pfo_o,
  output logic              cal_mode_o,
  output logic              cal_sign_o,
  output logic [CAL_W-1:0]  cal_mag_o
);
  time_bank_t cnt, bank;
  logic freeze, load, century, cal_en;

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze), .load_i(load),
    .load_val_i(bank), .cnt_o(cnt), .century_o(century)
  );

  rtc_user_regs u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .cnt_i(cnt), .century_i(century),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .freeze_o(freeze), .load_o(load),
    .bank_o(bank), .cal_en_o(cal_en), .cal_sign_o(cal_sign_o), .cal_mag_o(cal_mag_o)
  );

  assign cal_mode_o = cal_en;
  assign cal_pfo_o  = cal_en ? cal_clk_i : pfail_i;

  assert_pin_mux_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode_o |-> (cal_pfo_o == pfail_i));
endmodule

// File: tb/rtc_snap_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_snap_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [3:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic rsp_valid_o, cal_pfo_o, cal_mode_o, cal_sign_o;
  logic [7:0] rsp_rdata_o;
  logic [4:0] cal_mag_o;
  logic cal_clk_i = 1'b0, pfail_i = 1'b0;

  int checks = 0, fails = 0;
  int ms, mm, mh, mdw, mdt, mmo, my;
  bit w_exp = 0, cf_exp = 0;

  always #10 clk = ~clk;

  rtc_snap_ctrl u_rtc_snap_ctrl (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int model_field(input int i);
    case (i)
      0: return ms;  1: return mm;  2: return mh;  3: return mdw;
      4: return mdt; 5: return mmo; default: return my;
    endcase
  endfunction

  task automatic model_tick();
    if (w_exp) return;
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mdw = (mdw == 7) ? 1 : mdw + 1; mdt++;
          if (mdt > mdays(mmo, my)) begin
            mdt = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin my = 0; cf_exp = 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 4'(a); req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    req_valid_i = 1; req_write_i = 0; req_addr_i = 4'(a);
    @(negedge clk);
    req_valid_i = 0;
    d = rsp_valid_o ? rsp_rdata_o : 8'hxx;
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0;
    model_tick();
  endtask

  task automatic set_time(input int s, m, h, dw, dt, mo, y);
    wr(0, 8'h02); w_exp = 1;
    ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; my = y;
    for (int i = 0; i < 7; i++) wr(2 + i, bcd(model_field(i)));
    wr(0, 8'h00); w_exp = 0;
  endtask

  task automatic capture_check(input string req);
    logic [7:0] d;
    wr(0, 8'h01); wr(0, 8'h00);
    for (int i = 0; i < 7; i++) begin
      rd(2 + i, d);
      check(req, d, bcd(model_field(i)));
    end
  endtask

  task automatic check_cf(input string req);
    logic [7:0] d;
    rd(0, d);
    check(req, d, cf_exp ? 8'h40 : 8'h00);
    cf_exp = 0;
  endtask

  task automatic sweep(input int s, m, h, dw, dt, mo, y, n, input string req);
    set_time(s, m, h, dw, dt, mo, y);
    for (int k = 0; k < n; k++) begin
      tick();
      capture_check(req);
    end
    check_cf("R8 century flag after sweep");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; my = 0;
    rd(0, d); check("R12 control reset", d, 8'h00);
    rd(1, d); check("R12 calib reset", d, 8'h00);
    for (int i = 0; i < 7; i++) begin
      rd(2 + i, d); check("R12 time reset", d, bcd(model_field(i)));
    end
    rd(15, d); check("R1 unused address", d, 8'h00);
    wr(15, 8'hAA); rd(15, d); check("R1 unused write ignored", d, 8'h00);

    // R2 R3 R4 boundary sweeps
    sweep(58, 59, 23, 3, 28, 2, 24, 4, "R3 leap february");
    sweep(58, 59, 23, 3, 28, 2, 23, 4, "R3 plain february");
    sweep(58, 59, 23, 7, 28, 2, 0,  4, "R3 year 00 leap");
    sweep(59, 59, 23, 2, 30, 4, 15, 3, "R3 thirty day month");
    sweep(59, 59, 23, 5, 31, 1, 42, 3, "R3 january end");
    sweep(55, 59, 23, 6, 31, 12, 99, 7, "R3 century wrap");
    set_time(0, 0, 0, 1, 1, 1, 50);
    for (int k = 1; k <= 4000; k++) begin
      tick();
      if (k % 97 == 0) capture_check("R2 long run");
    end
    capture_check("R4 capture image");

    // R5 held capture bit
    wr(0, 8'h01);
    snap = bcd(ms);
    tick(); tick(); tick();
    wr(0, 8'h01);
    rd(2, d); check("R5 held bit no capture", d, snap);
    wr(0, 8'h00);
    capture_check("R5 next capture live");

    // R6 freeze, R7 load
    wr(0, 8'h02); w_exp = 1;
    repeat (5) tick();
    wr(2, 8'h42);
    rd(2, d); check("R6 frozen bank reads written", d, 8'h42);
    rd(3, d); check("R6 frozen bank reads captured", d, bcd(mm));
    @(negedge clk); tick_i = 1; req_valid_i = 1; req_write_i = 1; req_addr_i = 0; req_wdata_i = 8'h00;
    @(negedge clk); tick_i = 0; req_valid_i = 0; req_write_i = 0;
    w_exp = 0; ms = 42;
    capture_check("R7 load on release");
    tick();
    capture_check("R7 counting resumes");

    // R8 same-cycle wrap and read
    set_time(59, 59, 23, 4, 31, 12, 99);
    @(negedge clk); tick_i = 1; req_valid_i = 1; req_write_i = 0; req_addr_i = 0;
    @(negedge clk); tick_i = 0; req_valid_i = 0;
    check("R8 read shows old flag", rsp_rdata_o, 8'h00);
    model_tick();
    rd(0, d); check("R8 set wins over clear", d, 8'h40);
    rd(0, d); check("R8 read clears", d, 8'h00);
    capture_check("R3 new century time");

    // R9 reserved bits, R8 flag not writable, R11 pin
    wr(0, 8'hFF); w_exp = 1;
    rd(0, d); check("R9 reserved read zero", d, 8'h07);
    cal_clk_i = 1; pfail_i = 0; #1;
    check("R11 calib follows clock", {7'b0, cal_pfo_o}, 8'h01);
    check("R11 mode output", {7'b0, cal_mode_o}, 8'h01);
    cal_clk_i = 0; pfail_i = 1; #1;
    check("R11 calib ignores pfail", {7'b0, cal_pfo_o}, 8'h00);
    wr(0, 8'h00); w_exp = 0;
    #1;
    check("R11 pfail follows", {7'b0, cal_pfo_o}, 8'h01);
    check("R11 mode off", {7'b0, cal_mode_o}, 8'h00);
    capture_check("R7 load of unchanged bank");

    // R10 calibration register
    wr(1, 8'hFF); rd(1, d); check("R10 calib read", d, 8'h3F);
    check("R10 sign out", {7'b0, cal_sign_o}, 8'h01);
    check("R10 magnitude out", {3'b0, cal_mag_o}, 8'h1F);
    wr(1, 8'h0A); rd(1, d); check("R10 calib read 2", d, 8'h0A);
    check("R10 sign out 2", {7'b0, cal_sign_o}, 8'h00);
    check("R10 magnitude out 2", {3'b0, cal_mag_o}, 8'h0A);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule